// File: doc/BRIEF.md
# Linear Position Result and Control Register Bank

This block sits between a 10-bit conversion source and a byte-wide register port. Every accepted conversion passes through an optional polarity flip and, in the slow setting, a four-sample average before it lands in a result register. The result is published over two byte addresses. The upper byte also carries an even-parity bit over the ten result bits and a flag that shows whether the offset compensation loop has settled.

The same bank holds the front-end controls: power-down, polarity, slow/fast speed and a two-bit sensitivity code. It also mirrors a 10-bit offset value from the compensation loop as read-only bytes. A reader fetches the low byte first. That read freezes a copy of the whole result, so the following upper-byte read always belongs to the same sample.

Top module: `hall_result_regs`

## Requirements
- R1: After synchronous reset, addresses 0x00, 0x01, 0x02 and 0x0B read 0x00, and ctl_pwrdn, ctl_slow and ctl_sens are 0.
- R2: In fast mode (0x02 bit 2 = 0) each smp_valid sample is latched at the clock edge where it is presented. Address 0x00 returns result bits 7:0 and address 0x01 bits 1:0 return result bits 9:8.
- R3: With polarity reversal set (0x02 bit 1 = 1), the value stored is 1023 minus the sample.
- R4: In slow mode (0x02 bit 2 = 1), accepted samples are gathered in groups of four. Only the fourth sample updates the result, to floor(sum/4). The group restarts whenever slow mode is off or power-down is on.
- R5: Address 0x01 bit 2 is the even-parity bit: the XOR of the ten result bits returned with it.
- R6: Address 0x01 bit 3 is the compensation flag. A comp_done pulse sets it while active. It is cleared while power-down is set, and stays 0 after wake-up until comp_done is seen again.
- R7: Address 0x02 bit 0 is power-down, driven on ctl_pwrdn. While it is set, samples are ignored and the result holds.
- R8: Reading 0x00 captures the current result. A later read of 0x01 returns the upper bits and parity of that captured value, even if newer samples have arrived.
- R9: Address 0x03 returns offset_in bits 7:0 and address 0x04 bits 1:0 return offset_in bits 9:8. Writes to them have no effect.
- R10: Address 0x0B bits 1:0 hold the sensitivity code on ctl_sens, encoded as 0 for ±50 mT, 1 for ±25 mT, 2 for ±12.5 mT and 3 for ±18.75 mT. ctl_slow mirrors 0x02 bit 2.
- R11: Unlisted addresses and unlisted bits read as 0. Writes to any address other than 0x02 and 0x0B, and to unlisted bits, change nothing.
- R12: reg_rdata presents the addressed value on the clock edge that samples reg_rd and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Conversion sample strobe |
| smp_data | input | 10 | Raw conversion sample |
| comp_done | input | 1 | Offset compensation finished pulse |
| offset_in | input | 10 | Offset value from compensation loop |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, registered |
| ctl_pwrdn | output | 1 | Power-down request to front end |
| ctl_slow | output | 1 | Slow sampling request to front end |
| ctl_sens | output | 2 | Sensitivity code to front end |

## Verification
The bench targets the split read. A design without the frozen copy would return upper bits from a newer sample after 0x00 was read. The slow-mode groups are checked at the fourth sample and at full scale. An average that published early, or a sum that overflowed at 4×1023, would show a wrong or early result. The compensation flag is followed through a power-down cycle, because a flag that came back on its own after wake-up would hide an unsettled loop. Writes to read-only and unlisted locations are checked against a reference model that ignores them, so a decoder that aliased addresses would show up as a changed control or result.

// File: rtl/hall_pkg.sv
package hall_pkg;

    localparam int REG_W = 8;

    localparam logic [7:0] RA_RES_LO  = 8'h00;
    localparam logic [7:0] RA_RES_HI  = 8'h01;
    localparam logic [7:0] RA_CTRL    = 8'h02;
    localparam logic [7:0] RA_OFFS_LO = 8'h03;
    localparam logic [7:0] RA_OFFS_HI = 8'h04;
    localparam logic [7:0] RA_SENS    = 8'h0B;

    typedef struct packed {
        logic slow;
        logic invert;
        logic pwrdn;
    } ctrl_t;

    typedef enum logic [1:0] {
        SENS_50MT  = 2'd0,
        SENS_25MT  = 2'd1,
        SENS_12MT5 = 2'd2,
        SENS_18MT75 = 2'd3
    } sens_e;

    function automatic logic even_par(input logic [15:0] v);
        return ^v;
    endfunction

endpackage

// File: rtl/hall_sample_proc.sv
module hall_sample_proc #(
    parameter int SMP_W    = 10,
    parameter int AVG_LOG2 = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    input  hall_pkg::ctrl_t  ctrl,
    output logic [SMP_W-1:0] result
);
    localparam int AVG_N = 1 << AVG_LOG2;
    localparam int ACC_W = SMP_W + AVG_LOG2;
    localparam int CNT_W = (AVG_LOG2 > 0) ? AVG_LOG2 : 1;

    logic [SMP_W-1:0] conv;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_sum;
    logic [CNT_W-1:0] cnt_q;
    logic [SMP_W-1:0] result_q;
    logic             grp_last;

    // All-ones minus x equals bitwise inversion of x.
    assign conv     = ctrl.invert ? ~smp_data : smp_data;
    assign acc_sum  = acc_q + ACC_W'(conv);
    assign grp_last = (cnt_q == CNT_W'(AVG_N - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            acc_q    <= '0;
            cnt_q    <= '0;
        end else if (ctrl.pwrdn || !ctrl.slow) begin
            acc_q <= '0;
            cnt_q <= '0;
            if (!ctrl.pwrdn && smp_valid) begin
                result_q <= conv;
            end
        end else if (smp_valid) begin
            if (grp_last) begin
                result_q <= acc_sum[ACC_W-1:AVG_LOG2];
                acc_q    <= '0;
                cnt_q    <= '0;
            end else begin
                acc_q <= acc_sum;
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign result = result_q;

    AST_PD_HOLD: assert property (@(posedge clk) disable iff (rst)
        ctrl.pwrdn |=> $stable(result_q)); // R7

    AST_SLOW_MID_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ctrl.slow && !ctrl.pwrdn && smp_valid && !grp_last) |=> $stable(result_q)); // R4

endmodule

// File: rtl/hall_ctrl_regs.sv
module hall_ctrl_regs #(
    parameter int ADDR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [hall_pkg::REG_W-1:0] wdata,
    input  logic                     comp_done,
    output hall_pkg::ctrl_t          ctrl,
    output hall_pkg::sens_e          sens,
    output logic                     comp_flag
);
    import hall_pkg::*;

    ctrl_t ctrl_q;
    sens_e sens_q;
    logic  flag_q;
    logic  hit_ctrl;
    logic  hit_sens;

    assign hit_ctrl = wr && (addr == ADDR_W'(RA_CTRL));
    assign hit_sens = wr && (addr == ADDR_W'(RA_SENS));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            sens_q <= SENS_50MT;
        end else begin
            if (hit_ctrl) begin
                ctrl_q.pwrdn  <= wdata[0];
                ctrl_q.invert <= wdata[1];
                ctrl_q.slow   <= wdata[2];
            end
            if (hit_sens) begin
                sens_q <= sens_e'(wdata[1:0]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (ctrl_q.pwrdn) begin
            flag_q <= 1'b0;
        end else if (comp_done) begin
            flag_q <= 1'b1;
        end
    end

    assign ctrl      = ctrl_q;
    assign sens      = sens_q;
    assign comp_flag = flag_q;

    AST_FLAG_CLR_PD: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.pwrdn |=> !flag_q); // R6

    AST_CTRL_WR_ONLY: assert property (@(posedge clk) disable iff (rst)
        !hit_ctrl |=> $stable(ctrl_q)); // R11

    AST_SENS_WR_ONLY: assert property (@(posedge clk) disable iff (rst)
        !hit_sens |=> $stable(sens_q)); // R10

endmodule

// File: rtl/hall_read_port.sv
module hall_read_port #(
    parameter int SMP_W  = 10,
    parameter int ADDR_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rd,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [SMP_W-1:0]           result,
    input  logic                       comp_flag,
    input  hall_pkg::ctrl_t            ctrl,
    input  hall_pkg::sens_e            sens,
    input  logic [SMP_W-1:0]           offset,
    output logic [hall_pkg::REG_W-1:0] rdata
);
    import hall_pkg::*;

    localparam int HI_W = SMP_W - REG_W;

    logic [SMP_W-1:0] shadow_q;
    logic [REG_W-1:0] rdata_q;
    logic [REG_W-1:0] hi_byte;
    logic [REG_W-1:0] offs_hi;
    logic [REG_W-1:0] rd_val;
    logic             known;

    always_comb begin
        hi_byte               = '0;
        hi_byte[HI_W-1:0]     = shadow_q[SMP_W-1:REG_W];
        hi_byte[HI_W]         = even_par(16'(shadow_q));
        hi_byte[HI_W+1]       = comp_flag;
        offs_hi               = '0;
        offs_hi[HI_W-1:0]     = offset[SMP_W-1:REG_W];
    end

    always_comb begin
        rd_val = '0;
        known  = 1'b1;
        unique case (addr)
            ADDR_W'(RA_RES_LO):  rd_val = result[REG_W-1:0];
            ADDR_W'(RA_RES_HI):  rd_val = hi_byte;
            ADDR_W'(RA_CTRL):    rd_val = {5'b0, ctrl.slow, ctrl.invert, ctrl.pwrdn};
            ADDR_W'(RA_OFFS_LO): rd_val = offset[REG_W-1:0];
            ADDR_W'(RA_OFFS_HI): rd_val = offs_hi;
            ADDR_W'(RA_SENS):    rd_val = {6'b0, sens};
            default:             known  = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            rdata_q  <= '0;
        end else if (rd) begin
            rdata_q <= rd_val;
            if (addr == ADDR_W'(RA_RES_LO)) begin
                shadow_q <= result;
            end
        end
    end

    assign rdata = rdata_q;

    AST_UNLISTED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd && !known) |=> (rdata_q == '0)); // R11

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(rdata_q)); // R12

    AST_SHADOW_KEEP: assert property (@(posedge clk) disable iff (rst)
        !(rd && addr == ADDR_W'(RA_RES_LO)) |=> $stable(shadow_q)); // R8

endmodule

// File: rtl/hall_result_regs.sv
module hall_result_regs #(
    parameter int SMP_W    = 10,
    parameter int AVG_LOG2 = 2,
    parameter int ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_data,
    input  logic              comp_done,
    input  logic [SMP_W-1:0]  offset_in,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    input  logic              reg_rd,
    output logic [7:0]        reg_rdata,
    output logic              ctl_pwrdn,
    output logic              ctl_slow,
    output logic [1:0]        ctl_sens
);
    import hall_pkg::*;

    ctrl_t            ctrl;
    sens_e            sens;
    logic             comp_flag;
    logic [SMP_W-1:0] result;

    hall_ctrl_regs #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .comp_done (comp_done),
        .ctrl      (ctrl),
        .sens      (sens),
        .comp_flag (comp_flag)
    );

    hall_sample_proc #(.SMP_W(SMP_W), .AVG_LOG2(AVG_LOG2)) u_proc (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .ctrl      (ctrl),
        .result    (result)
    );

    hall_read_port #(.SMP_W(SMP_W), .ADDR_W(ADDR_W)) u_rdp (
        .clk       (clk),
        .rst       (rst),
        .rd        (reg_rd),
        .addr      (reg_addr),
        .result    (result),
        .comp_flag (comp_flag),
        .ctrl      (ctrl),
        .sens      (sens),
        .offset    (offset_in),
        .rdata     (reg_rdata)
    );

    assign ctl_pwrdn = ctrl.pwrdn;
    assign ctl_slow  = ctrl.slow;
    assign ctl_sens  = sens;

    AST_FAST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && !ctrl.pwrdn && !ctrl.slow && !ctrl.invert)
        |=> (result == $past(smp_data))); // R2

    AST_INVERT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && !ctrl.pwrdn && !ctrl.slow && ctrl.invert)
        |=> (result == SMP_W'((1 << SMP_W) - 1) - $past(smp_data))); // R3

endmodule

// File: tb/hall_result_regs_tb_top.sv
module hall_result_regs_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_valid = 1'b0;
    logic [9:0] smp_data = '0;
    logic       comp_done = 1'b0;
    logic [9:0] offset_in = 10'h2A5;
    logic [7:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_rdata;
    logic       ctl_pwrdn;
    logic       ctl_slow;
    logic [1:0] ctl_sens;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    int m_res = 0, m_shadow = 0, m_stat = 0;
    int m_pd = 0, m_inv = 0, m_slow = 0, m_sens = 0;
    int pend[$];

    always #10 clk = ~clk;

    hall_result_regs dut_i (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .comp_done(comp_done), .offset_in(offset_in), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata), .ctl_pwrdn(ctl_pwrdn), .ctl_slow(ctl_slow),
        .ctl_sens(ctl_sens)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // control outputs compared with the model on every clock (R7, R10)
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R7 ctl_pwrdn", int'(ctl_pwrdn), m_pd);
            check("R10 ctl_slow", int'(ctl_slow), m_slow);
            check("R10 ctl_sens", int'(ctl_sens), m_sens);
        end
    end

    function automatic int par10(input int v);
        int p = 0;
        for (int i = 0; i < 10; i++) p ^= (v >> i) & 1;
        return p;
    endfunction

    function automatic int model_read(input int a);
        case (a)
            0: return m_res & 8'hFF;
            1: return ((m_shadow >> 8) & 3) | (par10(m_shadow) << 2) | (m_stat << 3);
            2: return m_pd | (m_inv << 1) | (m_slow << 2);
            3: return int'(offset_in) & 8'hFF;
            4: return (int'(offset_in) >> 8) & 3;
            11: return m_sens;
            default: return 0;
        endcase
    endfunction

    task automatic do_write(input int a, input int d);
        @(negedge clk);
        reg_addr = 8'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
        @(posedge clk); #1;
        if (a == 2) begin
            m_pd = d & 1; m_inv = (d >> 1) & 1; m_slow = (d >> 2) & 1;
            if (m_pd != 0 || m_slow == 0) pend.delete();
            if (m_pd != 0) m_stat = 0;
        end else if (a == 11) begin
            m_sens = d & 3;
        end
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic check_read(input int a, input string req);
        int exp;
        @(negedge clk);
        reg_addr = 8'(a); reg_rd = 1'b1;
        @(posedge clk); #1;
        exp = model_read(a);
        check(req, int'(reg_rdata), exp);
        if (a == 0) m_shadow = m_res;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic send(input int x);
        int v;
        int s;
        @(negedge clk);
        smp_data = 10'(x); smp_valid = 1'b1;
        @(posedge clk); #1;
        if (m_pd == 0) begin
            v = (m_inv != 0) ? 1023 - x : x;
            if (m_slow != 0) begin
                pend.push_back(v);
                if (pend.size() == 4) begin
                    s = 0;
                    foreach (pend[i]) s += pend[i];
                    m_res = s >> 2;
                    pend.delete();
                end
            end else begin
                m_res = v;
            end
        end
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic pulse_comp();
        @(negedge clk);
        comp_done = 1'b1;
        @(posedge clk); #1;
        if (m_pd == 0) m_stat = 1;
        @(negedge clk);
        comp_done = 1'b0;
    endtask

    task automatic read_result(input string req);
        check_read(0, req);
        check_read(1, req);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check_read(0, "R1 reset 0x00");
        check_read(1, "R1 reset 0x01");
        check_read(2, "R1 reset 0x02");
        check_read(11, "R1 reset 0x0B");
        // R9 offset mirror
        check_read(3, "R9 offset low");
        check_read(4, "R9 offset high");
        offset_in = 10'h13C;
        check_read(3, "R9 offset low tracks");
        check_read(4, "R9 offset high tracks");

        // R2 / R5 fast capture with parity
        send(10'h1A5); read_result("R2 R5 fast 0x1A5");
        send(10'h3FF); read_result("R2 R5 fast 0x3FF");
        send(10'h000); read_result("R2 R5 fast 0x000");
        send(10'h2C3); read_result("R2 R5 fast 0x2C3");
        send(10'h101); send(10'h0FE); read_result("R2 back-to-back");

        // R8 frozen upper byte
        send(10'h2AA);
        check_read(0, "R8 latch low");
        send(10'h155);
        check_read(1, "R8 upper from frozen copy");
        check_read(0, "R8 new low");
        check_read(1, "R8 new upper");

        // R3 polarity reversal
        do_write(2, 8'h02);
        send(10'h005); read_result("R3 inverted 0x005");
        send(10'h3FF); read_result("R3 inverted 0x3FF");

        // R4 slow averaging
        do_write(2, 8'h04);
        send(10); send(20); send(30);
        check_read(0, "R4 no update mid group");
        send(41);
        read_result("R4 average of four");
        send(1023); send(1023); send(1023); send(1023);
        read_result("R4 full scale average");
        send(7); send(8);
        do_write(2, 8'h00);
        do_write(2, 8'h04);
        send(100); send(200); send(300);
        check_read(0, "R4 restart after leaving slow");
        send(400);
        read_result("R4 restarted group");
        do_write(2, 8'h06);
        send(0); send(3); send(5); send(9);
        read_result("R4 R3 slow inverted");
        do_write(2, 8'h00);

        // R6 / R7 power-down and compensation flag
        pulse_comp();
        check_read(1, "R6 flag set");
        do_write(2, 8'h01);
        send(10'h111);
        check_read(0, "R7 sample ignored in power-down");
        pulse_comp();
        check_read(1, "R6 flag cleared in power-down");
        do_write(2, 8'h00);
        repeat (3) @(posedge clk);
        check_read(1, "R6 flag stays clear after wake");
        pulse_comp();
        check_read(1, "R6 flag set again");
        send(10'h111);
        read_result("R7 sample accepted after wake");

        // R10 sensitivity codes
        for (int s = 0; s < 4; s++) begin
            do_write(11, s);
            check_read(11, "R10 sensitivity readback");
        end
        do_write(11, 8'hFE);
        check_read(11, "R11 sensitivity unlisted bits");

        // R11 ignored writes and unlisted reads
        do_write(2, 8'hF8);
        check_read(2, "R11 control unlisted bits");
        do_write(0, 8'h55);
        do_write(1, 8'hAA);
        do_write(3, 8'h77);
        do_write(5, 8'h33);
        read_result("R11 result after stray writes");
        check_read(2, "R11 control after stray writes");
        check_read(3, "R9 offset write ignored");
        check_read(5, "R11 unlisted address reads 0");
        check_read(8'hFF, "R11 top address reads 0");

        // R12 read data hold
        check_read(2, "R12 read value");
        send(10'h0C0);
        repeat (5) @(posedge clk);
        #1;
        check("R12 rdata held", int'(reg_rdata), model_read(2));

        repeat (2) @(posedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule